// File: doc/BRIEF.md
# One-Way Data Pump with Randomized Sender Acknowledge

The pump carries data words in a single direction, from a low-trust sender to a high-trust receiver. Words wait in a small first-in first-out store. Both sides use a valid/acknowledge handshake. The receiver can never send data back to the sender. The sender's acknowledge is also not a copy of the receiver's acknowledge, because that would leak the receiver's timing to the sender.

The pump measures each receiver acknowledge delay in clock cycles. It keeps the most recent delays in a circular history, together with their running sum. For every accepted word it draws a delay from a 16-bit LFSR. The delay is spread evenly above and below the window average, so the sender sees the receiver's long-run mean delay but not the individual delays.

The window size must be a power of two, because the average is taken with a right shift. The receiver delay count saturates at 2^DLY_W-1, and the history starts filled with a default delay.

Top module: `oneway_pump`

## Requirements
- R1: While rst_n is low at a clock edge, the next cycle shows lo_ack=0 and hi_valid=0, the buffer is empty, every history slot holds DEF_DLY, and the LFSR holds SEED.
- R2: A word is accepted at a clock edge only when all three hold: lo_valid is high, the pump is ready, and the buffer is not full. Each accepted word produces exactly one lo_ack pulse.
- R3: hi_valid is high exactly when the buffer is not empty. hi_data shows the oldest word and holds steady until hi_ack is sampled high. Words reach the receiver in the order they were accepted.
- R4: While the buffer holds DEPTH words, lo_valid is not accepted and no lo_ack is produced for it. The word is accepted at the first edge where a slot is free and the pump is ready.
- R5: The receiver delay is the number of cycles hi_valid was high for a word before the cycle in which hi_ack was sampled. A word acknowledged in its first cycle counts 0. The count saturates at 2^DLY_W-1.
- R6: The window average is floor(sum of the last WIN recorded receiver delays / WIN). The pump records a receiver delay when the word is popped.
- R7: At each acceptance the delay is D = avg + m when LFSR bit 0 is 0, and D = avg - m when it is 1. Here m = LFSR bits [DLY_W:1] ANDed with the largest 2^k-1 that is not above floor(avg/2). The LFSR uses the average from before that edge. It then steps once, shifting left with new bit 0 = b15^b13^b12^b10.
- R8: lo_ack is high for exactly one cycle, D+1 cycles after the cycle in which the word was accepted.
- R9: Receiver activity after an acceptance does not change the lo_ack timing of that word. It only affects delays drawn later.
- R10: No lo_ack appears unless a word was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lo_valid | input | 1 | Sender offers a word |
| lo_data | input | DATA_W | Sender word |
| lo_ack | output | 1 | One-cycle acknowledge to the sender |
| hi_valid | output | 1 | A word is offered to the receiver |
| hi_data | output | DATA_W | Word offered to the receiver |
| hi_ack | input | 1 | Receiver takes the offered word |

## Verification
A wrong history slot, sum or LFSR value does not show on hi_data. It shows only as a lo_ack that arrives one or more cycles early or late, at the next acceptance after the fault. A fault in the delay path therefore shows within one sender handshake. Buffer pointer or level faults show at once, as a wrong hi_data, a hi_valid that drops while words remain, or an acceptance made while the buffer is full. Comparing every cycle against the reference model catches a misplaced pulse in the cycle it occurs.

// File: rtl/pump_pkg.sv
package pump_pkg;
    // Sender-side phases: ready, holding the drawn delay, acknowledging
    typedef enum logic [1:0] {
        TX_READY = 2'd0,
        TX_HOLD  = 2'd1,
        TX_ACK   = 2'd2
    } tx_state_e;
endpackage

// File: rtl/pump_fifo.sv
module pump_fifo #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [DATA_W-1:0] rd_data,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LVL_W = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [PTR_W-1:0]             wp;
        logic [PTR_W-1:0]             rp;
        logic [LVL_W-1:0]             lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;

    function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            st_d.mem[st_q.wp] = wr_data;
            st_d.wp = nxt(st_q.wp);
        end
        if (rd_en) begin
            st_d.rp = nxt(st_q.rp);
        end
        case ({wr_en, rd_en})
            2'b10:   st_d.lvl = st_q.lvl + 1'b1;
            2'b01:   st_d.lvl = st_q.lvl - 1'b1;
            default: st_d.lvl = st_q.lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.mem[st_q.rp];
    assign level   = st_q.lvl;
    assign full    = (st_q.lvl == LVL_W'(DEPTH));
    assign empty   = (st_q.lvl == '0);
endmodule

// File: rtl/pump_delay_avg.sv
module pump_delay_avg #(
    parameter int WIN     = 4,
    parameter int DLY_W   = 5,
    parameter int DEF_DLY = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_en,
    input  logic [DLY_W-1:0] rec_dly,
    output logic [DLY_W-1:0] avg
);
    localparam int LOG_WIN = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int SUM_W   = DLY_W + LOG_WIN;

    typedef struct packed {
        logic [WIN-1:0][DLY_W-1:0] hist;
        logic [LOG_WIN-1:0]        ptr;
        logic [SUM_W-1:0]          sum;
    } avg_st_t;

    avg_st_t st_d, st_q, st_rst;

    always_comb begin
        for (int i = 0; i < WIN; i++) begin
            st_rst.hist[i] = DLY_W'(DEF_DLY);
        end
        st_rst.ptr = '0;
        st_rst.sum = SUM_W'(WIN * DEF_DLY);
    end

    always_comb begin
        st_d = st_q;
        if (rec_en) begin
            st_d.sum = st_q.sum - SUM_W'(st_q.hist[st_q.ptr]) + SUM_W'(rec_dly);
            st_d.hist[st_q.ptr] = rec_dly;
            st_d.ptr = (st_q.ptr == LOG_WIN'(WIN-1)) ? '0 : st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= st_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign avg = DLY_W'(st_q.sum >> $clog2(WIN));
endmodule

// File: rtl/pump_jitter.sv
module pump_jitter #(
    parameter int          DLY_W = 5,
    parameter logic [15:0] SEED  = 16'hACE1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             draw,
    input  logic [DLY_W-1:0] avg,
    output logic [DLY_W:0]   dly
);
    typedef struct packed {
        logic [15:0] lfsr;
    } jit_st_t;

    jit_st_t st_d, st_q;

    logic [DLY_W-1:0] half;
    logic [DLY_W-1:0] mask;
    logic [DLY_W-1:0] mag;

    always_comb begin
        half = avg >> 1;
        mask = '0;
        for (int k = 0; k <= DLY_W; k++) begin
            if (({DLY_W{1'b1}} >> (DLY_W - k)) <= half) begin
                mask = {DLY_W{1'b1}} >> (DLY_W - k);
            end
        end
        mag = st_q.lfsr[DLY_W:1] & mask;
        dly = st_q.lfsr[0] ? ({1'b0, avg} - {1'b0, mag})
                           : ({1'b0, avg} + {1'b0, mag});
    end

    always_comb begin
        st_d = st_q;
        if (draw) begin
            st_d.lfsr = {st_q.lfsr[14:0],
                         st_q.lfsr[15] ^ st_q.lfsr[13] ^ st_q.lfsr[12] ^ st_q.lfsr[10]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.lfsr <= SEED;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/oneway_pump.sv
module oneway_pump #(
    parameter int          DATA_W  = 8,
    parameter int          DEPTH   = 4,
    parameter int          WIN     = 4,
    parameter int          DLY_W   = 5,
    parameter int          DEF_DLY = 4,
    parameter logic [15:0] SEED    = 16'hACE1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lo_valid,
    input  logic [DATA_W-1:0] lo_data,
    output logic              lo_ack,
    output logic              hi_valid,
    output logic [DATA_W-1:0] hi_data,
    input  logic              hi_ack
);
    import pump_pkg::*;

    localparam int               LVL_W   = $clog2(DEPTH+1);
    localparam logic [DLY_W-1:0] CNT_MAX = {DLY_W{1'b1}};

    typedef struct packed {
        tx_state_e        tx;
        logic [DLY_W:0]   tmr;
        logic [DLY_W-1:0] wait_cnt;
    } top_st_t;

    top_st_t st_d, st_q;

    logic             take_word;
    logic             pop_word;
    logic             buf_full;
    logic             buf_empty;
    logic [LVL_W-1:0] fill_lvl;
    logic [DLY_W-1:0] win_avg;
    logic [DLY_W:0]   draw_dly;

    pump_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(take_word), .wr_data(lo_data),
        .rd_en(pop_word), .rd_data(hi_data),
        .level(fill_lvl), .full(buf_full), .empty(buf_empty)
    );

    pump_delay_avg #(.WIN(WIN), .DLY_W(DLY_W), .DEF_DLY(DEF_DLY)) u_avg (
        .clk(clk), .rst_n(rst_n),
        .rec_en(pop_word), .rec_dly(st_q.wait_cnt),
        .avg(win_avg)
    );

    pump_jitter #(.DLY_W(DLY_W), .SEED(SEED)) u_jit (
        .clk(clk), .rst_n(rst_n),
        .draw(take_word), .avg(win_avg),
        .dly(draw_dly)
    );

    assign take_word = (st_q.tx == TX_READY) && lo_valid && !buf_full;
    assign pop_word  = !buf_empty && hi_ack;

    always_comb begin
        st_d = st_q;
        case (st_q.tx)
            TX_READY: begin
                if (take_word) begin
                    st_d.tx  = TX_HOLD;
                    st_d.tmr = draw_dly;
                end
            end
            TX_HOLD: begin
                if (st_q.tmr == '0) begin
                    st_d.tx = TX_ACK;
                end else begin
                    st_d.tmr = st_q.tmr - 1'b1;
                end
            end
            default: st_d.tx = TX_READY;
        endcase

        if (pop_word || buf_empty) begin
            st_d.wait_cnt = '0;
        end else if (st_q.wait_cnt != CNT_MAX) begin
            st_d.wait_cnt = st_q.wait_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.tx       <= TX_READY;
            st_q.tmr      <= '0;
            st_q.wait_cnt <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_ack   = (st_q.tx == TX_ACK);
    assign hi_valid = !buf_empty;
endmodule

// File: rtl/pump_checker.sv
module pump_checker #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4,
    parameter int DLY_W  = 5
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       lo_ack,
    input logic                       hi_valid,
    input logic [DATA_W-1:0]          hi_data,
    input logic                       hi_ack,
    input logic [$clog2(DEPTH+1)-1:0] fill_lvl,
    input logic                       take_word,
    input logic [DLY_W-1:0]           win_avg,
    input logic [DLY_W:0]             draw_dly
);
    AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ack |=> !lo_ack); // R8

    AST_HEAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        hi_valid && !hi_ack |=> hi_valid && $stable(hi_data)); // R3

    AST_LEVEL_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= ($clog2(DEPTH+1))'(DEPTH)); // R4

    AST_NO_TAKE_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |-> fill_lvl < ($clog2(DEPTH+1))'(DEPTH)); // R4

    AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_lvl == '0) |-> !hi_valid); // R3

    AST_NO_ACK_WITH_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
        lo_ack |-> !take_word); // R10

    AST_DLY_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        take_word |-> ({2'b0, draw_dly} <= {2'b0, win_avg} + {3'b0, win_avg >> 1})
                   && ({2'b0, draw_dly} + {3'b0, win_avg >> 1} >= {2'b0, win_avg})); // R7
endmodule

bind oneway_pump pump_checker #(.DATA_W(DATA_W), .DEPTH(DEPTH), .DLY_W(DLY_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .lo_ack(lo_ack), .hi_valid(hi_valid),
    .hi_data(hi_data), .hi_ack(hi_ack), .fill_lvl(fill_lvl),
    .take_word(take_word), .win_avg(win_avg), .draw_dly(draw_dly)
);

// File: tb/sim_oneway_pump.sv
module sim_oneway_pump;
    localparam int DATA_W  = 8;
    localparam int DEPTH   = 4;
    localparam int WIN     = 4;
    localparam int DLY_W   = 5;
    localparam int DEF_DLY = 4;
    localparam int SEED    = 16'hACE1;
    localparam int CMAX    = (1 << DLY_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              lo_valid = 1'b0;
    logic [DATA_W-1:0] lo_data = '0;
    logic              lo_ack;
    logic              hi_valid;
    logic [DATA_W-1:0] hi_data;
    logic              hi_ack = 1'b0;

    always #2 clk = ~clk;

    oneway_pump #(.DATA_W(DATA_W), .DEPTH(DEPTH), .WIN(WIN), .DLY_W(DLY_W),
                  .DEF_DLY(DEF_DLY), .SEED(16'hACE1)) u0 (
        .clk(clk), .rst_n(rst_n), .lo_valid(lo_valid), .lo_data(lo_data),
        .lo_ack(lo_ack), .hi_valid(hi_valid), .hi_data(hi_data), .hi_ack(hi_ack)
    );

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference model
    int m_tx = 0;
    int m_tmr = 0;
    int m_cnt = 0;
    int m_hp = 0;
    int m_lfsr = SEED;
    int m_hist[WIN];
    int mq[$];

    // bench-side scoreboards
    int sent[$];
    int got[$];
    int n_ack = 0;
    int rx_lat = 0;
    int rx_wait = 0;
    bit rx_stall = 1'b0;
    int next_word = 1;

    task automatic check(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_tx = 0; m_tmr = 0; m_cnt = 0; m_hp = 0; m_lfsr = SEED;
            foreach (m_hist[i]) m_hist[i] = DEF_DLY;
            mq.delete();
        end else begin
            bit hv, pop, acc;
            int sum, avg, half, mask, mag, d, fb;
            hv  = mq.size() > 0;
            pop = hv && hi_ack;
            acc = (m_tx == 0) && lo_valid && (mq.size() < DEPTH);
            sum = 0;
            foreach (m_hist[i]) sum += m_hist[i];
            avg  = sum / WIN;
            half = avg / 2;
            mask = 0;
            for (int k = 0; k < 8; k++) if (((1 << k) - 1) <= half) mask = (1 << k) - 1;
            mag = (m_lfsr >> 1) & mask;
            d   = (m_lfsr & 1) ? avg - mag : avg + mag;
            case (m_tx)
                0: if (acc) begin
                    m_tx = 1; m_tmr = d;
                    fb = ((m_lfsr >> 15) ^ (m_lfsr >> 13) ^ (m_lfsr >> 12) ^ (m_lfsr >> 10)) & 1;
                    m_lfsr = ((m_lfsr << 1) | fb) & 16'hFFFF;
                end
                1: if (m_tmr == 0) m_tx = 2; else m_tmr--;
                default: m_tx = 0;
            endcase
            if (pop) begin
                m_hist[m_hp] = m_cnt;
                m_hp = (m_hp + 1) % WIN;
                void'(mq.pop_front());
                m_cnt = 0;
            end else if (hv) begin
                m_cnt = (m_cnt < CMAX) ? m_cnt + 1 : CMAX;
            end else begin
                m_cnt = 0;
            end
            if (acc) mq.push_back(int'(lo_data));
        end
    end

    // compare every cycle away from the active edge
    initial begin
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                check("R1 lo_ack in reset", int'(lo_ack), 0);
                check("R1 hi_valid in reset", int'(hi_valid), 0);
            end else begin
                check("lo_ack R2 R4 R5 R6 R7 R8 R9 R10", int'(lo_ack), (m_tx == 2) ? 1 : 0);
                check("hi_valid R3 R4", int'(hi_valid), (mq.size() > 0) ? 1 : 0);
                if (hi_valid && mq.size() > 0)
                    check("hi_data R3", int'(hi_data), mq[0]);
                if (lo_ack) n_ack++;
            end
        end
    end

    // receiver
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && hi_valid && !rx_stall) begin
                if (rx_wait >= rx_lat) begin
                    hi_ack = 1'b1;
                    got.push_back(int'(hi_data));
                    rx_wait = 0;
                end else begin
                    hi_ack = 1'b0;
                    rx_wait++;
                end
            end else begin
                hi_ack = 1'b0;
                rx_wait = 0;
            end
        end
    end

    task automatic send_words(int n, int gap);
        for (int i = 0; i < n; i++) begin
            lo_valid = 1'b1;
            lo_data  = DATA_W'(next_word);
            sent.push_back(next_word & 8'hFF);
            next_word = next_word * 7 + 3;
            do @(negedge clk); while (!lo_ack);
            lo_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R10: idle sender, no acknowledge may appear
        repeat (20) @(negedge clk);
        check("R10 no ack while idle", n_ack, 0);
        // R2 R7 R8: fast receiver, back-to-back words
        rx_lat = 0;
        send_words(10, 0);
        // R4 R6: slow receiver fills the buffer
        rx_lat = 20;
        send_words(10, 1);
        // R5: receiver slower than the saturation limit
        rx_lat = 40;
        send_words(6, 0);
        // R4 R9: receiver stalled, sender blocked, then released
        rx_stall = 1'b1;
        rx_lat = 3;
        fork
            send_words(6, 0);
            begin
                repeat (150) @(negedge clk);
                rx_stall = 1'b0;
            end
        join
        rx_lat = 1;
        send_words(8, 2);
        repeat (300) @(negedge clk);
        check("R2 one ack per word", n_ack, sent.size());
        check("R3 words delivered", got.size(), sent.size());
        for (int i = 0; i < sent.size() && i < got.size(); i++)
            check("R3 delivery order", got[i], sent[i]);
        check("R4 buffer drained", int'(hi_valid), 0);
        finish_run();
    end
endmodule